// File: doc/BRIEF.md
# Wait-State Peripheral Bus Bridge

This block sits between an 8-bit processor bus and an external 16-bit I/O bus that four peripheral slots share. The processor presents a chip select, an 8-bit register offset, a read/not-write flag and a data byte. The bridge splits the 256-byte window into four equal slots and drives one decoded select for each. For the disk slot it also drives a pair of device chip selects. It generates active-low read and write strobes and a 5-bit word address, and it drives or samples the shared 16-bit data bus.

An external cycle takes a fixed number of clocks. A hold output stalls the processor for the wait-state part of that cycle. Each 16-bit external register is seen as an even/odd byte pair on the processor side. An even-offset read runs the external cycle, returns the low byte and keeps the high byte in a latch. An odd-offset read is then answered from that latch. An odd-offset write only fills the latch. The following even-offset write sends the latched high byte and the new low byte in a single external cycle.

Top module: `pbus_bridge`

## Requirements
- R1: While `cpu_sel` is high, offset bits [7:6] pick the slot: value n raises `slot_sel[n]` alone (0x00–0x3F gives bit 0, 0x40–0x7F bit 1, 0x80–0xBF bit 2, 0xC0–0xFF bit 3).
- R2: An external access (a read or a write at an even offset) raises `cpu_hold` in the cycle the access is presented and keeps it high for exactly WAITS cycles (4 by default). The access completes in the first cycle in which hold is low.
- R3: An even-offset read holds `bus_rd_n` low for the whole access. In the completion cycle `cpu_rdata` equals `bus_data[7:0]`, and `bus_data[15:8]` is stored in the byte latch.
- R4: An odd-offset read returns the byte latch on `cpu_rdata`. It asserts no strobe and no hold.
- R5: An odd-offset write stores `cpu_wdata` in the byte latch. It asserts no strobe and no hold.
- R6: An even-offset write holds `bus_wr_n` low for the whole access and drives `bus_data` with {byte latch, `cpu_wdata`}.
- R7: `bus_reg` equals offset bits [5:1].
- R8: The bridge drives `bus_data` only while `bus_wr_n` is low. At all other times it leaves the bus released.
- R9: While `cpu_sel` is low, `cpu_hold` is low, both strobes are high and all four slot selects are low.
- R10: In slot 0, offset bit 4 low pulls `dsk_cmd_cs_n` low and bit 4 high pulls `dsk_ctl_cs_n` low. Outside slot 0 both stay high, and the two are never low together.
- R11: Reset clears the byte latch to 0 and returns the wait counter to idle, so the next external access again sees a full WAITS hold cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Chip select for the bridge window |
| cpu_offs | input | 8 | Byte offset inside the window |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Write byte from the processor |
| cpu_rdata | output | 8 | Read byte to the processor |
| cpu_hold | output | 1 | Stall request that stretches the processor cycle |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |
| bus_reg | output | 5 | External word register address |
| bus_data | inout | 16 | External data bus |
| slot_sel | output | 4 | Decoded slot selects, active high |
| dsk_cmd_cs_n | output | 1 | Disk slot command-block select, active low |
| dsk_ctl_cs_n | output | 1 | Disk slot control-block select, active low |

## Verification
The bench uses the default parameters: an 8-bit offset, four slots, a 16-bit external word and WAITS = 4. With these values one table walk reaches every slot boundary and both disk sub-selects. Every external access is checked over five cycles: four with hold high, then the completion cycle. A model device on the shared bus drives a known word whenever the write strobe is high. An illegal drive by the bridge therefore shows up as a corrupted value, and a reset issued during an access can be followed by a fresh access that must again be held for the full count.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    // Kind of processor access, decoded from select, direction and offset bit 0
    typedef enum logic [2:0] {
        ACC_NONE     = 3'd0,
        ACC_RD_EXT   = 3'd1,
        ACC_RD_LATCH = 3'd2,
        ACC_WR_LATCH = 3'd3,
        ACC_WR_EXT   = 3'd4
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic sel, input logic rnw, input logic odd);
        if (!sel)          return ACC_NONE;
        else if (rnw)      return odd ? ACC_RD_LATCH : ACC_RD_EXT;
        else               return odd ? ACC_WR_LATCH : ACC_WR_EXT;
    endfunction

endpackage

// File: rtl/pbus_slot_dec.sv
module pbus_slot_dec #(
    parameter int OFFS_W  = 8,
    parameter int SLOTS   = 4,
    parameter int SUB_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [OFFS_W-1:0] offs,
    output logic [SLOTS-1:0]  slot_sel,
    output logic [1:0]        sub_cs_n
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOT_W-1:0] slot_idx;

    always_comb begin
        slot_idx = offs[OFFS_W-1 -: SLOT_W];
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            slot_sel[g] = sel && (slot_idx == SLOT_W'(g));
        end
    end

    always_comb begin
        sub_cs_n[0] = !(slot_sel[0] && !offs[SUB_BIT]);
        sub_cs_n[1] = !(slot_sel[0] &&  offs[SUB_BIT]);
    end

    // R1
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> $countones(slot_sel) == 1);

    // R10
    sub_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sub_cs_n[0] == 1'b0 && sub_cs_n[1] == 1'b0));

    // R10
    sub_cs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_cs_n != 2'b11) |-> (sel && slot_idx == '0));

endmodule

// File: rtl/pbus_wait_ctr.sv
module pbus_wait_ctr #(
    parameter int WAITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    output logic hold,
    output logic done
);
    localparam int CNT_W = (WAITS < 1) ? 1 : $clog2(WAITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = ext_req && (st_q.cnt == CNT_W'(WAITS));
        hold = ext_req && !done;
        if (!ext_req || done) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Checker: length of the current run of hold cycles
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       run_q <= '0;
        else if (!hold)                   run_q <= '0;
        else if (run_q != {(CNT_W+1){1'b1}}) run_q <= run_q + (CNT_W+1)'(1);
    end

    // R2
    hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CNT_W+1)'(WAITS));

    // R2
    hold_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && ext_req) |-> run_q == (CNT_W+1)'(WAITS));

endmodule

// File: rtl/pbus_byte_lane.sv
module pbus_byte_lane
    import pbus_pkg::*;
#(
    parameter int CPU_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_kind_e          kind,
    input  logic               done,
    input  logic [2*CPU_W-1:0] ext_word,
    input  logic [CPU_W-1:0]   wdata,
    output logic [CPU_W-1:0]   rdata,
    output logic [2*CPU_W-1:0] drv_word
);
    typedef struct packed {
        logic [CPU_W-1:0] hi;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kind == ACC_RD_EXT && done) st_d.hi = ext_word[2*CPU_W-1:CPU_W];
        else if (kind == ACC_WR_LATCH)  st_d.hi = wdata;

        rdata    = (kind == ACC_RD_LATCH) ? st_q.hi : ext_word[CPU_W-1:0];
        drv_word = {st_q.hi, wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    latch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_LATCH) |=> st_q.hi == $past(wdata));

    // R3
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_RD_LATCH || kind == ACC_NONE) |=> $stable(st_q.hi));

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int OFFS_W  = 8,
    parameter int CPU_W   = 8,
    parameter int SLOTS   = 4,
    parameter int WAITS   = 4,
    parameter int SUB_BIT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_sel,
    input  logic [OFFS_W-1:0]           cpu_offs,
    input  logic                        cpu_rnw,
    input  logic [CPU_W-1:0]            cpu_wdata,
    output logic [CPU_W-1:0]            cpu_rdata,
    output logic                        cpu_hold,
    output logic                        bus_rd_n,
    output logic                        bus_wr_n,
    output logic [OFFS_W-$clog2(SLOTS)-2:0] bus_reg,
    inout  wire  [2*CPU_W-1:0]          bus_data,
    output logic [SLOTS-1:0]            slot_sel,
    output logic                        dsk_cmd_cs_n,
    output logic                        dsk_ctl_cs_n
);
    localparam int EXT_W  = 2 * CPU_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int REG_W  = OFFS_W - SLOT_W - 1;

    acc_kind_e        kind;
    logic             ext_req;
    logic             done;
    logic [EXT_W-1:0] drv_word;
    logic [1:0]       sub_cs_n;

    always_comb begin
        kind     = classify(cpu_sel, cpu_rnw, cpu_offs[0]);
        ext_req  = (kind == ACC_RD_EXT) || (kind == ACC_WR_EXT);
        bus_rd_n = !(kind == ACC_RD_EXT);
        bus_wr_n = !(kind == ACC_WR_EXT);
        bus_reg  = cpu_offs[REG_W:1];
        dsk_cmd_cs_n = sub_cs_n[0];
        dsk_ctl_cs_n = sub_cs_n[1];
    end

    assign bus_data = bus_wr_n ? {EXT_W{1'bz}} : drv_word;

    pbus_slot_dec #(
        .OFFS_W  (OFFS_W),
        .SLOTS   (SLOTS),
        .SUB_BIT (SUB_BIT)
    ) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (cpu_sel),
        .offs     (cpu_offs),
        .slot_sel (slot_sel),
        .sub_cs_n (sub_cs_n)
    );

    pbus_wait_ctr #(
        .WAITS (WAITS)
    ) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_req (ext_req),
        .hold    (cpu_hold),
        .done    (done)
    );

    pbus_byte_lane #(
        .CPU_W (CPU_W)
    ) i_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .done     (done),
        .ext_word (bus_data),
        .wdata    (cpu_wdata),
        .rdata    (cpu_rdata),
        .drv_word (drv_word)
    );

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_n == 1'b0 && bus_wr_n == 1'b0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> (!cpu_hold && bus_rd_n && bus_wr_n && slot_sel == '0));

    // R4
    latch_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_offs[0]) |-> (!cpu_hold && bus_rd_n && bus_wr_n));

    // R2
    hold_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> (!bus_rd_n || !bus_wr_n));

endmodule

// File: tb/test_pbus_bridge.sv
`timescale 1ns/1ps
module test_pbus_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel;
    logic [7:0]  cpu_offs;
    logic        cpu_rnw;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        cpu_hold;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [4:0]  bus_reg;
    wire  [15:0] bus_data;
    logic [3:0]  slot_sel;
    logic        dsk_cmd_cs_n;
    logic        dsk_ctl_cs_n;
    logic [15:0] dev_word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    // Model device: answers whenever the bridge is not writing
    assign bus_data = bus_wr_n ? dev_word : 16'hzzzz;

    pbus_bridge i_pbus_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_sel      (cpu_sel),
        .cpu_offs     (cpu_offs),
        .cpu_rnw      (cpu_rnw),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_hold     (cpu_hold),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_reg      (bus_reg),
        .bus_data     (bus_data),
        .slot_sel     (slot_sel),
        .dsk_cmd_cs_n (dsk_cmd_cs_n),
        .dsk_ctl_cs_n (dsk_ctl_cs_n)
    );

    // {offset, slot_sel, cmd_cs_n, ctl_cs_n, bus_reg}
    localparam logic [18:0] VEC [9] = '{
        {8'h00, 4'b0001, 1'b0, 1'b1, 5'd0},
        {8'h13, 4'b0001, 1'b1, 1'b0, 5'd9},
        {8'h3F, 4'b0001, 1'b1, 1'b0, 5'd31},
        {8'h40, 4'b0010, 1'b1, 1'b1, 5'd0},
        {8'h6A, 4'b0010, 1'b1, 1'b1, 5'd21},
        {8'h80, 4'b0100, 1'b1, 1'b1, 5'd0},
        {8'hB7, 4'b0100, 1'b1, 1'b1, 5'd27},
        {8'hC0, 4'b1000, 1'b1, 1'b1, 5'd0},
        {8'hFE, 4'b1000, 1'b1, 1'b1, 5'd31}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_check();
        chk(!cpu_hold && bus_rd_n && bus_wr_n && slot_sel == 4'b0, "R9 idle outputs",
            {cpu_hold, bus_rd_n, bus_wr_n, slot_sel}, {1'b0, 1'b1, 1'b1, 4'b0});
    endtask

    // Run an external access already driven at this negedge; sample each cycle
    task automatic ext_access(input logic is_rd, input logic [7:0] exp_rd, input logic [15:0] exp_wr);
        for (int k = 0; k <= 4; k++) begin
            #2;
            chk(cpu_hold == (k < 4), "R2 hold window", cpu_hold, (k < 4));
            if (is_rd) begin
                chk(!bus_rd_n && bus_wr_n, "R3 read strobe", {bus_rd_n, bus_wr_n}, 2'b01);
                if (k == 4) chk(cpu_rdata == exp_rd, "R3 low byte", cpu_rdata, exp_rd);
            end else begin
                chk(!bus_wr_n && bus_rd_n, "R6 write strobe", {bus_rd_n, bus_wr_n}, 2'b10);
                chk(bus_data == exp_wr, "R6 write word", bus_data, exp_wr);
            end
            @(negedge clk);
        end
        cpu_sel = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_sel = 1'b0; cpu_offs = '0; cpu_rnw = 1'b1;
        cpu_wdata = '0; dev_word = 16'h1234;
        repeat (3) @(negedge clk);
        #2;
        chk(!cpu_hold && bus_rd_n && bus_wr_n, "R11 reset outputs",
            {cpu_hold, bus_rd_n, bus_wr_n}, 3'b011);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R4: latch is zero after reset
        cpu_sel = 1'b1; cpu_offs = 8'h01; cpu_rnw = 1'b1;
        #2;
        chk(cpu_rdata == 8'h00, "R11 latch cleared", cpu_rdata, 8'h00);
        chk(!cpu_hold && bus_rd_n, "R4 no cycle on odd read", {cpu_hold, bus_rd_n}, 2'b01);
        @(negedge clk);
        cpu_sel = 1'b0;

        // R1 R7 R10: table walk
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            cpu_sel = 1'b1; cpu_offs = VEC[i][18:11]; cpu_rnw = 1'b1;
            #2;
            chk(slot_sel == VEC[i][10:7], "R1 slot decode", slot_sel, VEC[i][10:7]);
            chk({dsk_cmd_cs_n, dsk_ctl_cs_n} == VEC[i][6:5], "R10 disk sub-select",
                {dsk_cmd_cs_n, dsk_ctl_cs_n}, VEC[i][6:5]);
            chk(bus_reg == VEC[i][4:0], "R7 register address", bus_reg, VEC[i][4:0]);
            @(negedge clk);
            cpu_sel = 1'b0;
            #2;
            idle_check();
        end

        // R3 then R4: even read then odd read from latch
        @(negedge clk);
        dev_word = 16'hBEEF;
        cpu_sel = 1'b1; cpu_offs = 8'h44; cpu_rnw = 1'b1;
        ext_access(1'b1, 8'hEF, 16'h0);
        cpu_sel = 1'b1; cpu_offs = 8'h45; cpu_rnw = 1'b1;
        dev_word = 16'h0000;
        #2;
        chk(cpu_rdata == 8'hBE, "R4 high byte from latch", cpu_rdata, 8'hBE);
        chk(!cpu_hold && bus_rd_n && bus_wr_n, "R4 odd read quiet",
            {cpu_hold, bus_rd_n, bus_wr_n}, 3'b011);
        @(negedge clk);

        // R5: odd write fills latch only
        cpu_sel = 1'b1; cpu_offs = 8'h0B; cpu_rnw = 1'b0; cpu_wdata = 8'h5A;
        #2;
        chk(!cpu_hold && bus_rd_n && bus_wr_n, "R5 odd write quiet",
            {cpu_hold, bus_rd_n, bus_wr_n}, 3'b011);
        @(negedge clk);
        cpu_rnw = 1'b1;
        #2;
        chk(cpu_rdata == 8'h5A, "R5 latch holds written byte", cpu_rdata, 8'h5A);
        @(negedge clk);

        // R6 R7: even write combines latch and new low byte
        dev_word = 16'h1234;
        cpu_sel = 1'b1; cpu_offs = 8'h0A; cpu_rnw = 1'b0; cpu_wdata = 8'h3C;
        #2;
        chk(bus_reg == 5'd5, "R7 write address", bus_reg, 5'd5);
        @(negedge clk);
        cpu_sel = 1'b0;
        @(negedge clk);
        cpu_sel = 1'b1;
        ext_access(1'b0, 8'h0, 16'h5A3C);

        // R8: released bus shows only the device word
        cpu_wdata = 8'h0F;
        #2;
        chk(bus_data == 16'h1234, "R8 bus released when idle", bus_data, 16'h1234);
        idle_check();
        @(negedge clk);
        cpu_sel = 1'b1; cpu_offs = 8'h21; cpu_rnw = 1'b1;
        #2;
        chk(bus_data == 16'h1234, "R8 bus released on latch read", bus_data, 16'h1234);
        @(negedge clk);
        cpu_sel = 1'b0;

        // R11: reset during an access
        @(negedge clk);
        dev_word = 16'h7777;
        cpu_sel = 1'b1; cpu_offs = 8'h02; cpu_rnw = 1'b1;
        repeat (2) @(negedge clk);
        cpu_sel = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cpu_sel = 1'b1; cpu_offs = 8'h03;
        #2;
        chk(cpu_rdata == 8'h00, "R11 latch cleared by reset", cpu_rdata, 8'h00);
        @(negedge clk);
        cpu_offs = 8'h02;
        ext_access(1'b1, 8'h77, 16'h0);
        #2;
        idle_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule